// File: doc/BRIEF.md
# TDM Audio Transmit Slot Serializer

This block drives one serial audio data line in a time-division multiplexed frame of eight slots. Each time slot lasts a programmed number of bit clocks. At the first bit of each slot the block takes a 32-bit sample word through a valid/ready handshake. It cuts the sample to the selected word size, places the word inside the slot, fills the unused slot bits by a chosen rule, and then shifts the result out one bit per bit-clock enable, in either bit order.

A 32-bit control word sets the formatting. It also sets a disable flag for each slot, the line level during disabled slots (low, high or released), the policy when no sample is ready (send zero or repeat the last word), mono duplication of the left channel into the right-channel slot, and compact-stereo packing, where one input word carries both channels of a slot pair. The surrounding system supplies a single-cycle bit clock enable and a frame-start strobe. The block's outputs are the data bit, an output-enable for a tri-state pad, and a one-cycle underrun flag.

Top module: `tdm_tx_serializer`

## Requirements
- R1: During and after reset, until the first frame start, txData, txOe, underrun and sampleReady are all low.
- R2: A cycle with bitEn and frameStart both high emits bit 0 of slot 0. Each slot lasts slotWidth bit-enable cycles and the frame ends after slot 7. The first bit-enable cycle after the frame ends drives txData and txOe low. The outputs change only on cycles with bitEn high, and they are registered, so they appear after that clock edge.
- R3: ctrlWord[10:8] selects the word size N: 0 gives 32 bits, 1 gives 24, 2 gives 20, 3 gives 18, 4 and 5 give 16, 6 and 7 give 8. Codes 5 and 7 are the compact variants.
- R4: In non-compact sizes, ctrlWord[12]=0 takes the sample from input bits N-1:0. ctrlWord[12]=1 takes it from input bits 31:32-N.
- R5: The slot is a slotWidth-bit value. With ctrlWord[7]=0 the sample sits in its low N bits; with ctrlWord[7]=1 it sits in its high N bits. ctrlWord[14:13] fills the other bits: 0 with zeros, 1 with ones, 2 with copies of the sample MSB, 3 with copies of the sample LSB.
- R6: ctrlWord[15]=0 sends the slot value from its top bit down. ctrlWord[15]=1 sends it from bit 0 up.
- R7: ctrlWord[16+k]=1 disables slot k. A disabled slot takes no sample and drives idle code ctrlWord[3:2]: 0 or 2 gives txData low with txOe high, 1 gives txData high with txOe high, 3 gives txOe low.
- R8: When a slot needs a sample and sampleValid is low, underrun pulses high for one clock. If ctrlWord[4]=1 the last accepted word is used again; if ctrlWord[4]=0 a zero word is used and it becomes the new last word.
- R9: With ctrlWord[24]=1, odd (right-channel) slots take no sample and send the sample of the word last taken for an even slot.
- R10: In compact sizes, one word is taken at the start of an even slot if either slot of the pair is enabled. Without mono, the even slot sends input bits N-1:0 and the odd slot sends bits 2N-1:N. With mono, both slots send bits N-1:0. ctrlWord[12] has no effect in compact sizes.
- R11: sampleReady is high only in the bit-enable cycle that starts a slot needing a sample. A word is consumed when sampleValid and sampleReady are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle bit clock enable |
| frameStart | input | 1 | Frame start, qualified by bitEn |
| slotWidth | input | 6 | Bit clocks per slot, 8 to 32, at least N |
| ctrlWord | input | 32 | Formatting and slot control word |
| sampleData | input | 32 | Sample word |
| sampleValid | input | 1 | Sample word available |
| sampleReady | output | 1 | Sample word taken this cycle |
| txData | output | 1 | Serial data bit |
| txOe | output | 1 | Output enable for the data pad |
| underrun | output | 1 | One-cycle pulse when a needed sample was missing |

## Verification
The hardest state to reach is the interaction of the held word with the slot-pair rules. Examples are an odd slot in mono or compact mode that must reuse a word taken one slot earlier, and an underrun in repeat mode that must send a word accepted frames before. The stimulus limits the number of samples offered, so underruns land mid-frame in a chosen mode. It then runs the following frame in the other underrun mode, and it disables the even half of a compact pair so that a word is taken in a slot that sends nothing.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int CTRL_W    = 32;
  localparam int BIT_CNT_W = 6;

  typedef enum logic [1:0] {
    FILL_ZERO   = 2'd0,
    FILL_ONE    = 2'd1,
    FILL_TOP    = 2'd2,
    FILL_BOTTOM = 2'd3
  } fillMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic                 emit;
    logic                 first;
    logic                 fetch;
    logic                 slotOn;
    logic                 odd;
    logic [BIT_CNT_W-1:0] bitIdx;
  } txStrobe_t;

  function automatic logic [BIT_CNT_W-1:0] sizeBits(input logic [2:0] code);
    case (code)
      3'd0:       return BIT_CNT_W'(32);
      3'd1:       return BIT_CNT_W'(24);
      3'd2:       return BIT_CNT_W'(20);
      3'd3:       return BIT_CNT_W'(18);
      3'd4, 3'd5: return BIT_CNT_W'(16);
      default:    return BIT_CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitEn,
  input  logic                 frameStart,
  input  logic [BIT_CNT_W-1:0] slotWidth,
  input  logic [NUM_SLOTS-1:0] slotOff,
  input  logic                 compact,
  input  logic                 mono,
  output txStrobe_t            strobe
);
  localparam int SIDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [SIDX_W-1:0] LAST_SLOT = SIDX_W'(NUM_SLOTS - 1);

  logic                 running;
  logic [SIDX_W-1:0]    nSlot, curSlot;
  logic [BIT_CNT_W-1:0] nBit, curBit;
  logic                 emit, lastBit, slotOn, odd, needData, firstBit;

  always_comb begin
    emit     = bitEn & (frameStart | running);
    curSlot  = frameStart ? '0 : nSlot;
    curBit   = frameStart ? '0 : nBit;
    lastBit  = (curBit == slotWidth - BIT_CNT_W'(1));
    firstBit = (curBit == '0);
    slotOn   = ~slotOff[curSlot];
    odd      = curSlot[0];
    if (compact) needData = ~odd & (slotOn | ~slotOff[curSlot | SIDX_W'(1)]);
    else         needData = slotOn & ~(mono & odd);
    strobe.emit   = emit;
    strobe.first  = firstBit;
    strobe.fetch  = emit & firstBit & needData;
    strobe.slotOn = slotOn;
    strobe.odd    = odd;
    strobe.bitIdx = curBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      nSlot   <= '0;
      nBit    <= '0;
    end else if (emit) begin
      if (lastBit) begin
        nBit    <= '0;
        nSlot   <= curSlot + SIDX_W'(1);
        running <= (curSlot != LAST_SLOT);
      end else begin
        nBit    <= curBit + BIT_CNT_W'(1);
        nSlot   <= curSlot;
        running <= 1'b1;
      end
    end
  end

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (nBit < slotWidth));

  // R11
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fetch |=> !strobe.fetch);
endmodule

// File: rtl/tdm_tx_dpath.sv
module tdm_tx_dpath
  import tdm_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitEn,
  input  txStrobe_t            strobe,
  input  logic [BIT_CNT_W-1:0] slotWidth,
  input  logic [1:0]           idleCode,
  input  logic                 repeatLast,
  input  logic                 slotLeft,
  input  logic [2:0]           sizeCode,
  input  logic                 wordLeft,
  input  fillMode_e            fillSel,
  input  logic                 lsbFirst,
  input  logic                 compact,
  input  logic                 mono,
  input  logic [CTRL_W-1:0]    sampleData,
  input  logic                 sampleValid,
  output logic                 txData,
  output logic                 txOe,
  output logic                 underrun
);
  logic [CTRL_W-1:0]    held, slotReg, newHeld, srcWord, sample, maskN;
  logic [CTRL_W-1:0]    inMask, aligned, slotNew, txWord;
  logic [BIT_CNT_W-1:0] nBits, shAmt, offset, bitSel;
  logic                 fillBit;

  always_comb begin
    nBits   = sizeBits(sizeCode);
    maskN   = (nBits == BIT_CNT_W'(CTRL_W)) ? '1 : ((CTRL_W'(1) << nBits) - CTRL_W'(1));
    newHeld = sampleValid ? sampleData : (repeatLast ? held : '0);
    srcWord = strobe.fetch ? newHeld : held;
    if (compact) shAmt = (strobe.odd & ~mono) ? nBits : '0;
    else         shAmt = wordLeft ? (BIT_CNT_W'(CTRL_W) - nBits) : '0;
    sample  = (srcWord >> shAmt) & maskN;
    fillBit = 1'b0;
    case (fillSel)
      FILL_ZERO:   fillBit = 1'b0;
      FILL_ONE:    fillBit = 1'b1;
      FILL_TOP:    fillBit = sample[5'(nBits - BIT_CNT_W'(1))];
      FILL_BOTTOM: fillBit = sample[0];
      default:     fillBit = 1'b0;
    endcase
    offset  = slotLeft ? (slotWidth - nBits) : '0;
    inMask  = maskN << offset;
    aligned = sample << offset;
    slotNew = aligned | ({CTRL_W{fillBit}} & ~inMask);
    txWord  = strobe.first ? slotNew : slotReg;
    bitSel  = lsbFirst ? strobe.bitIdx : (slotWidth - BIT_CNT_W'(1) - strobe.bitIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held     <= '0;
      slotReg  <= '0;
      txData   <= 1'b0;
      txOe     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= strobe.fetch & ~sampleValid;
      if (strobe.fetch) held <= newHeld;
      if (strobe.emit & strobe.first) slotReg <= slotNew;
      if (strobe.emit) begin
        if (strobe.slotOn) begin
          txData <= txWord[5'(bitSel)];
          txOe   <= 1'b1;
        end else begin
          txData <= (idleCode == 2'd1);
          txOe   <= (idleCode != 2'd3);
        end
      end else if (bitEn) begin
        txData <= 1'b0;
        txOe   <= 1'b0;
      end
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitEn) |-> ($stable(txData) && $stable(txOe)));

  // R8
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);

  // R8
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetch && !sampleValid && repeatLast) |=> $stable(held));

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !strobe.slotOn && idleCode == 2'd3) |=> !txOe);
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitEn,
  input  logic                 frameStart,
  input  logic [BIT_CNT_W-1:0] slotWidth,
  input  logic [CTRL_W-1:0]    ctrlWord,
  input  logic [CTRL_W-1:0]    sampleData,
  input  logic                 sampleValid,
  output logic                 sampleReady,
  output logic                 txData,
  output logic                 txOe,
  output logic                 underrun
);
  localparam int OFF_LO = 16;

  txStrobe_t strobe;
  logic      compact;
  logic      unusedCtrl;

  assign compact     = (ctrlWord[10:8] == 3'd5) || (ctrlWord[10:8] == 3'd7);
  assign sampleReady = strobe.fetch;
  assign unusedCtrl  = ^{ctrlWord[31:25], ctrlWord[11], ctrlWord[6:5], ctrlWord[1:0]};

  tdm_tx_ctrl #(.NUM_SLOTS(NUM_SLOTS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .frameStart (frameStart),
    .slotWidth  (slotWidth),
    .slotOff    (ctrlWord[OFF_LO +: NUM_SLOTS]),
    .compact    (compact),
    .mono       (ctrlWord[24]),
    .strobe     (strobe)
  );

  tdm_tx_dpath i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .bitEn       (bitEn),
    .strobe      (strobe),
    .slotWidth   (slotWidth),
    .idleCode    (ctrlWord[3:2]),
    .repeatLast  (ctrlWord[4]),
    .slotLeft    (ctrlWord[7]),
    .sizeCode    (ctrlWord[10:8]),
    .wordLeft    (ctrlWord[12]),
    .fillSel     (fillMode_e'(ctrlWord[14:13])),
    .lsbFirst    (ctrlWord[15]),
    .compact     (compact),
    .mono        (ctrlWord[24]),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .txData      (txData),
    .txOe        (txOe),
    .underrun    (underrun)
  );
endmodule

// File: tb/test_tdm_tx_serializer.sv
module test_tdm_tx_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 8;

  logic        clk = 1'b0, rstN = 1'b0, bitEn = 1'b0, frameStart = 1'b0;
  logic [5:0]  slotWidth = 6'd32;
  logic [31:0] ctrlWord = '0, sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady, txData, txOe, underrun;

  int total = 0, bad = 0;
  int avail, bIdx, mIdx, expTaken, expUnder, gotTaken, gotUnder, holdBad;
  logic [31:0] mHeld;
  logic [31:0] smp [16];
  logic [31:0] capD [SLOTS], capOe [SLOTS], expD [SLOTS], expOe [SLOTS];

  tdm_tx_serializer i_tdm_tx_serializer (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
    .slotWidth(slotWidth), .ctrlWord(ctrlWord), .sampleData(sampleData),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .txData(txData),
    .txOe(txOe), .underrun(underrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int mSize(input logic [2:0] c);
    case (c)
      3'd0: return 32;
      3'd1: return 24;
      3'd2: return 20;
      3'd3: return 18;
      3'd4, 3'd5: return 16;
      default: return 8;
    endcase
  endfunction

  // slot value per R3..R5, R10
  function automatic logic [31:0] mSlot(input logic [31:0] raw, input logic rightHalf);
    int n = mSize(ctrlWord[10:8]);
    bit cmp = (ctrlWord[10:8] == 3'd5) || (ctrlWord[10:8] == 3'd7);
    logic [31:0] s = '0;
    logic f;
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      if (cmp)               s[i] = raw[i + (rightHalf ? n : 0)];
      else if (ctrlWord[12]) s[i] = raw[32 - n + i];
      else                   s[i] = raw[i];
    end
    case (ctrlWord[14:13])
      2'd0: f = 1'b0;
      2'd1: f = 1'b1;
      2'd2: f = s[n-1];
      default: f = s[0];
    endcase
    v = {32{f}};
    for (int i = 0; i < n; i++) v[ctrlWord[7] ? (int'(slotWidth) - n + i) : i] = s[i];
    return v;
  endfunction

  task automatic modelFrame();
    int w = int'(slotWidth);
    bit cmp = (ctrlWord[10:8] == 3'd5) || (ctrlWord[10:8] == 3'd7);
    bit mono = ctrlWord[24];
    expTaken = 0; expUnder = 0;
    for (int s = 0; s < SLOTS; s++) begin
      bit off = ctrlWord[16+s];
      bit odd = (s % 2) == 1;
      bit need;
      logic [31:0] v;
      if (cmp) need = !odd && (!off || !ctrlWord[16+s+1]);
      else     need = !off && !(mono && odd);
      if (need) begin
        if (mIdx < avail) begin mHeld = smp[mIdx]; mIdx++; expTaken++; end
        else begin expUnder++; if (!ctrlWord[4]) mHeld = '0; end
      end
      v = mSlot(mHeld, odd && !mono);
      expD[s] = '0; expOe[s] = '0;
      for (int k = 0; k < w; k++) begin
        if (off) begin
          expD[s][k]  = (ctrlWord[3:2] == 2'd1);
          expOe[s][k] = (ctrlWord[3:2] != 2'd3);
        end else begin
          expD[s][k]  = ctrlWord[15] ? v[k] : v[w-1-k];
          expOe[s][k] = 1'b1;
        end
      end
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; bitEn = 1'b0; frameStart = 1'b0; sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mHeld = '0; bIdx = 0; mIdx = 0;
    @(negedge clk);
  endtask

  task automatic runFrame(input string tag, input bit gap);
    int w = int'(slotWidth);
    logic pd, po;
    modelFrame();
    for (int s = 0; s < SLOTS; s++) begin capD[s] = '0; capOe[s] = '0; end
    gotTaken = 0; gotUnder = 0; holdBad = 0;
    for (int t = 0; t <= SLOTS * w; t++) begin
      bitEn = 1'b1;
      frameStart = (t == 0);
      sampleValid = (bIdx < avail);
      sampleData = sampleValid ? smp[bIdx] : 32'hDEAD_BEEF;
      #1;
      if (sampleReady && sampleValid) begin bIdx++; gotTaken++; end
      @(negedge clk);
      if (underrun) gotUnder++;
      if (t < SLOTS * w) begin
        capD[t / w][t % w]  = txData;
        capOe[t / w][t % w] = txOe;
      end else begin
        check(tag, "line after frame end (R2)", {txOe, txData}, 2'b00);
      end
      if (gap) begin
        bitEn = 1'b0; frameStart = 1'b0;
        pd = txData; po = txOe;
        @(negedge clk);
        if (txData !== pd || txOe !== po) holdBad++;
        if (underrun) gotUnder++;
      end
    end
    bitEn = 1'b0; sampleValid = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      check(tag, $sformatf("slot %0d data", s), capD[s], expD[s]);
      check(tag, $sformatf("slot %0d enable", s), capOe[s], expOe[s]);
    end
    check(tag, "samples taken (R11)", gotTaken, expTaken);
    check(tag, "underrun pulses (R8)", gotUnder, expUnder);
    if (gap) check(tag, "hold between bit enables (R2)", holdBad, 0);
  endtask

  task automatic loadSamples(input logic [31:0] seed);
    for (int i = 0; i < 16; i++) smp[i] = seed ^ (32'h9E37_79B9 * (i + 1));
  endtask

  task automatic testReset();
    rstN = 1'b0; bitEn = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "outputs in reset", {txData, txOe, underrun, sampleReady}, 4'b0000);
    bitEn = 1'b0; rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "outputs after reset", {txData, txOe, underrun, sampleReady}, 4'b0000);
    bitEn = 1'b1;
    @(negedge clk);
    check("R1", "no frame before frame start", {txOe, sampleReady}, 2'b00);
    bitEn = 1'b0;
  endtask

  task automatic testDefault();
    doReset(); loadSamples(32'h1357_9BDF); avail = 16;
    ctrlWord = '0; slotWidth = 6'd32;
    runFrame("R2 R3 R11 default", 1'b0);
  endtask

  task automatic testWordLeft();
    doReset(); avail = 16;
    smp[0] = 32'h8123_4500; smp[1] = 32'h1234_5600; loadSamples(32'hA5A5_0F0F);
    smp[0] = 32'h8123_4500; smp[1] = 32'h1234_5600;
    ctrlWord = (32'd1 << 8) | (32'd1 << 12) | (32'd2 << 13); slotWidth = 6'd32;
    runFrame("R3 R4 R5 24-bit word-left msb-fill", 1'b0);
  endtask

  task automatic testSlotLeftLsb();
    doReset(); loadSamples(32'h0F1E_2D3C); avail = 16;
    ctrlWord = (32'd4 << 8) | (32'd1 << 7) | (32'd1 << 13) | (32'd1 << 15); slotWidth = 6'd20;
    runFrame("R5 R6 16-bit slot-left ones lsb-first", 1'b0);
  endtask

  task automatic testSmallSizes();
    doReset(); loadSamples(32'h6666_1111); avail = 16;
    ctrlWord = (32'd6 << 8) | (32'd3 << 13); slotWidth = 6'd8;
    runFrame("R3 R5 8-bit lsb-fill full slot", 1'b0);
    ctrlWord = (32'd2 << 8) | (32'd1 << 7) | (32'd3 << 13); slotWidth = 6'd24;
    runFrame("R3 R5 20-bit slot-left lsb-fill", 1'b0);
    ctrlWord = (32'd3 << 8) | (32'd1 << 12) | (32'd2 << 13); slotWidth = 6'd24;
    runFrame("R3 R4 18-bit word-left", 1'b0);
  endtask

  task automatic testDisabled();
    doReset(); loadSamples(32'h0BAD_F00D); avail = 16;
    slotWidth = 6'd16;
    ctrlWord = (32'h12 << 16) | (32'd1 << 2) | (32'd4 << 8);
    runFrame("R7 idle high", 1'b0);
    ctrlWord = (32'h81 << 16) | (32'd3 << 2) | (32'd4 << 8);
    runFrame("R7 idle released", 1'b0);
    ctrlWord = (32'h08 << 16) | (32'd4 << 8);
    runFrame("R7 idle low", 1'b0);
  endtask

  task automatic testUnderrun();
    doReset(); loadSamples(32'hC001_D00D); avail = 5;
    slotWidth = 6'd16;
    ctrlWord = (32'd1 << 4) | (32'd4 << 8);
    runFrame("R8 repeat last", 1'b0);
    ctrlWord = (32'd4 << 8);
    runFrame("R8 zero fill", 1'b0);
  endtask

  task automatic testMono();
    doReset(); loadSamples(32'h7777_ABCD); avail = 16;
    slotWidth = 6'd24; ctrlWord = (32'd1 << 24) | (32'd1 << 8);
    runFrame("R9 mono", 1'b0);
  endtask

  task automatic testCompact();
    doReset(); loadSamples(32'h2468_ACE0); avail = 16;
    slotWidth = 6'd16; ctrlWord = (32'd5 << 8) | (32'h04 << 16) | (32'd1 << 12);
    runFrame("R10 compact 16 partner disabled", 1'b0);
    slotWidth = 6'd8; ctrlWord = (32'd7 << 8) | (32'd1 << 24);
    runFrame("R10 compact 8 mono", 1'b0);
    ctrlWord = (32'd7 << 8);
    runFrame("R10 compact 8", 1'b0);
  endtask

  task automatic testGaps();
    doReset(); loadSamples(32'h5A5A_3C3C); avail = 16;
    slotWidth = 6'd8; ctrlWord = (32'd6 << 8);
    runFrame("R2 sparse bit enable", 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testDefault();
    testWordLeft();
    testSlotLeftLsb();
    testSmallSizes();
    testDisabled();
    testUnderrun();
    testMono();
    testCompact();
    testGaps();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule